// File: doc/BRIEF.md
# UART Line Status and Interrupt Logic

This block holds the line status word of a UART whose receiver can run with a single holding location or with a receive FIFO. It sees receive events as they happen: a character arriving with its parity, framing and break tags, and the host taking a character from the head. From these it keeps the data-ready, overrun, per-character error and FIFO-error flags. It also follows the transmit side through two level inputs, one for the holding register or transmit FIFO and one for the shift register. The character storage, the shift registers and the serial line are outside the block.

So that each error tag can be shown when its character reaches the head, the block keeps a small shadow queue of 3-bit tags. The queue advances in step with the real receive buffer. The 8-bit status word and both interrupt requests are registered. Each one reflects the inputs of the previous clock edge.

Top module: `line_status_unit`

## Requirements
- R1: In the cycle after a synchronous reset the status word reads 8'h60 (only bits 5 and 6 set), and both interrupt requests are low.
- R2: Bit 0 is 1 from the cycle after the buffer becomes non-empty and returns to 0 in the cycle after it becomes empty. Capacity is 1 character with `fifo_mode` low and RX_DEPTH with it high. A take (`rx_pop`) while empty is ignored.
- R3: A character offered while the buffer is full sets bit 1 in the next cycle. A take in the same cycle frees one slot. The dropped character is not queued and its tags are never reported.
- R4: A pulse on `status_rd` clears bits 1 to 4 in the next cycle. It leaves bits 0, 5 and 6 unchanged.
- R5: If an error event and `status_rd` occur in the same cycle, the error bit is set in the next cycle.
- R6: With `fifo_mode` high, a character's tags set bit 2 (parity), bit 3 (framing) and bit 4 (break) only when that character becomes the head. This happens when it enters an empty buffer, or when a take moves it forward. Tags on characters behind the head are not shown.
- R7: With `fifo_mode` low, the tags of an accepted character are shown in the cycle after it arrives.
- R8: Bit 7 is set, only with `fifo_mode` high, while any buffered character carries a tag. After it has been set, it is cleared by a status read only when no tagged character remains.
- R9: Bit 5 equals `tx_hold_empty` and bit 6 equals `tx_hold_empty` AND `tx_shift_empty`, each sampled one cycle earlier. Status reads do not affect them.
- R10: `rls_irq` is 1 exactly when `rls_irq_en` was 1 at the previous edge and any of bits 1 to 4 is set.
- R11: `thre_irq` is 1 exactly when `thre_irq_en` was 1 at the previous edge and bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 selects the receive FIFO, 0 the single holding location; change only while empty |
| rx_push | input | 1 | A received character is offered to the buffer |
| rx_par_err | input | 1 | Parity tag of the offered character |
| rx_frm_err | input | 1 | Framing tag of the offered character |
| rx_brk | input | 1 | Break tag of the offered character |
| rx_pop | input | 1 | Host takes the head character |
| tx_hold_empty | input | 1 | Transmit holding register or FIFO is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| status_rd | input | 1 | Host read strobe for the status word |
| rls_irq_en | input | 1 | Enable for the receiver line status interrupt |
| thre_irq_en | input | 1 | Enable for the transmit-empty interrupt |
| lsr | output | 8 | Status word: 0 ready, 1 overrun, 2 parity, 3 framing, 4 break, 5 transmit holding empty, 6 transmitter empty, 7 FIFO error |
| rls_irq | output | 1 | Receiver line status interrupt request |
| thre_irq | output | 1 | Transmit holding empty interrupt request |

## Verification
The in-line assertions check invariants on every cycle:
- an offered character always leaves bit 0 set;
- a drop always sets the overrun flag, and a read without a new drop clears it;
- bit 6 never shows without bit 5, and bit 7 never shows after a cycle outside FIFO mode;
- the line status request never rises without its enable;
- the shadow queue never exceeds its depth or counts more tagged characters than it holds.

Only the bench scenarios can show that a tag stays hidden behind the head and then appears as its character advances. The same holds for bit 7 outliving the tagged characters until the next read, and for a same-cycle read losing against a new error. These are compared against a queue model on every clock, in both modes and across mode changes.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  localparam int LSR_READY    = 0;
  localparam int LSR_OVERRUN  = 1;
  localparam int LSR_PARITY   = 2;
  localparam int LSR_FRAMING  = 3;
  localparam int LSR_BREAK    = 4;
  localparam int LSR_THR_IDLE = 5;
  localparam int LSR_TX_IDLE  = 6;
  localparam int LSR_FIFO_ERR = 7;

endpackage

// File: rtl/rx_tag_queue.sv
module rx_tag_queue
  import lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    fifo_mode,
  input  logic    push,
  input  logic    pop,
  input  rx_tag_t tag_in,
  output logic    overrun,
  output logic    head_new,
  output rx_tag_t head_tag,
  output logic    occupied_next,
  output logic    err_any_next
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IX  = AW'(DEPTH - 1);

  rx_tag_t        mem_q [DEPTH];
  logic [AW-1:0]  rd_q, wr_q;
  logic [CW-1:0]  count_q, err_q;
  logic [CW-1:0]  count_d, err_d, cap, level_after_pop;
  logic           pop_ok, push_ok, leaving_err, entering_err;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_IX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cap             = fifo_mode ? FULL_LVL : CW'(1);
    pop_ok          = pop && (count_q != '0);
    level_after_pop = count_q - CW'(pop_ok);
    push_ok         = push && (level_after_pop < cap);
    overrun         = push && !push_ok;
    count_d         = level_after_pop + CW'(push_ok);

    head_new = 1'b0;
    head_tag = tag_in;
    if (pop_ok && (count_q > CW'(1))) begin
      head_new = 1'b1;
      head_tag = mem_q[bump(rd_q)];
    end else if (push_ok && (level_after_pop == '0)) begin
      head_new = 1'b1;
      head_tag = tag_in;
    end

    leaving_err  = pop_ok && (|mem_q[rd_q]);
    entering_err = push_ok && (|tag_in);
    err_d        = err_q + CW'(entering_err) - CW'(leaving_err);

    occupied_next = (count_d != '0);
    err_any_next  = (err_d != '0);
  end

  // tag storage: write-only port with no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= '0;
      err_q   <= '0;
    end else begin
      if (pop_ok)  rd_q <= bump(rd_q);
      if (push_ok) wr_q <= bump(wr_q);
      count_q <= count_d;
      err_q   <= err_d;
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_LVL);  // R2
  AST_ERR_WITHIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    err_q <= count_q);  // R8

endmodule

// File: rtl/rx_error_flags.sv
module rx_error_flags
  import lsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    fifo_mode,
  input  logic    status_read,
  input  logic    overrun,
  input  logic    head_new,
  input  rx_tag_t head_tag,
  input  logic    err_any_next,
  output logic    oe_q,
  output logic    pe_q,
  output logic    fe_q,
  output logic    bi_q,
  output logic    fifo_err_q,
  output logic    any_err_next
);

  logic oe_d, pe_d, fe_d, bi_d, fifo_err_d;
  logic keep;

  always_comb begin
    keep       = !status_read;
    // a new event outranks a read in the same cycle
    oe_d       = overrun | (oe_q & keep);
    pe_d       = (head_new & head_tag.par) | (pe_q & keep);
    fe_d       = (head_new & head_tag.frm) | (fe_q & keep);
    bi_d       = (head_new & head_tag.brk) | (bi_q & keep);
    fifo_err_d = fifo_mode & (err_any_next | (fifo_err_q & keep));
    any_err_next = oe_d | pe_d | fe_d | bi_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q       <= 1'b0;
      pe_q       <= 1'b0;
      fe_q       <= 1'b0;
      bi_q       <= 1'b0;
      fifo_err_q <= 1'b0;
    end else begin
      oe_q       <= oe_d;
      pe_q       <= pe_d;
      fe_q       <= fe_d;
      bi_q       <= bi_d;
      fifo_err_q <= fifo_err_d;
    end
  end

  AST_DROP_SETS_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    overrun |=> oe_q);  // R3
  AST_READ_CLEARS_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (status_read && !overrun) |=> !oe_q);  // R4
  AST_HEAD_PARITY_SHOWN: assert property (@(posedge clk) disable iff (rst)
    (head_new && head_tag.par) |=> pe_q);  // R6

endmodule

// File: rtl/tx_status.sv
module tx_status (
  input  logic clk,
  input  logic rst,
  input  logic hold_empty,
  input  logic shift_empty,
  input  logic thre_en,
  output logic thre_q,
  output logic temt_q,
  output logic thre_irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      thre_q     <= 1'b1;
      temt_q     <= 1'b1;
      thre_irq_q <= 1'b0;
    end else begin
      thre_q     <= hold_empty;
      temt_q     <= hold_empty & shift_empty;
      thre_irq_q <= thre_en & hold_empty;
    end
  end

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (rst)
    temt_q |-> thre_q);  // R9
  AST_THRE_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    thre_irq_q |-> thre_q);  // R11

endmodule

// File: rtl/line_status_unit.sv
module line_status_unit
  import lsr_pkg::*;
#(
  parameter int RX_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fifo_mode,
  input  logic       rx_push,
  input  logic       rx_par_err,
  input  logic       rx_frm_err,
  input  logic       rx_brk,
  input  logic       rx_pop,
  input  logic       tx_hold_empty,
  input  logic       tx_shift_empty,
  input  logic       status_rd,
  input  logic       rls_irq_en,
  input  logic       thre_irq_en,
  output logic [7:0] lsr,
  output logic       rls_irq,
  output logic       thre_irq
);

  rx_tag_t tag_in, head_tag;
  logic    overrun, head_new, occupied_next, err_any_next;
  logic    oe_q, pe_q, fe_q, bi_q, fifo_err_q, any_err_next;
  logic    thre_q, temt_q;
  logic    ready_q, rls_q;

  assign tag_in = '{brk: rx_brk, frm: rx_frm_err, par: rx_par_err};

  rx_tag_queue #(.DEPTH(RX_DEPTH)) u_queue (
    .clk          (clk),
    .rst          (rst),
    .fifo_mode    (fifo_mode),
    .push         (rx_push),
    .pop          (rx_pop),
    .tag_in       (tag_in),
    .overrun      (overrun),
    .head_new     (head_new),
    .head_tag     (head_tag),
    .occupied_next(occupied_next),
    .err_any_next (err_any_next)
  );

  rx_error_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .fifo_mode   (fifo_mode),
    .status_read (status_rd),
    .overrun     (overrun),
    .head_new    (head_new),
    .head_tag    (head_tag),
    .err_any_next(err_any_next),
    .oe_q        (oe_q),
    .pe_q        (pe_q),
    .fe_q        (fe_q),
    .bi_q        (bi_q),
    .fifo_err_q  (fifo_err_q),
    .any_err_next(any_err_next)
  );

  tx_status u_tx (
    .clk        (clk),
    .rst        (rst),
    .hold_empty (tx_hold_empty),
    .shift_empty(tx_shift_empty),
    .thre_en    (thre_irq_en),
    .thre_q     (thre_q),
    .temt_q     (temt_q),
    .thre_irq_q (thre_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      rls_q   <= 1'b0;
    end else begin
      ready_q <= occupied_next;
      rls_q   <= rls_irq_en & any_err_next;
    end
  end

  always_comb begin
    lsr               = '0;
    lsr[LSR_READY]    = ready_q;
    lsr[LSR_OVERRUN]  = oe_q;
    lsr[LSR_PARITY]   = pe_q;
    lsr[LSR_FRAMING]  = fe_q;
    lsr[LSR_BREAK]    = bi_q;
    lsr[LSR_THR_IDLE] = thre_q;
    lsr[LSR_TX_IDLE]  = temt_q;
    lsr[LSR_FIFO_ERR] = fifo_err_q;
  end

  assign rls_irq = rls_q;

  AST_PUSH_SHOWS_READY: assert property (@(posedge clk) disable iff (rst)
    rx_push |=> lsr[LSR_READY]);  // R2
  AST_RLS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    rls_irq |-> $past(rls_irq_en));  // R10
  AST_RLS_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    rls_irq |-> (|lsr[LSR_BREAK:LSR_OVERRUN]));  // R10
  AST_FIFO_ERR_MODE_ONLY: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_mode) |-> !lsr[LSR_FIFO_ERR]);  // R8

endmodule

// File: tb/line_status_unit_test.sv
`timescale 1ns/1ps
module line_status_unit_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, fifo_mode = 1'b0, rx_push = 1'b0, rx_par_err = 1'b0;
  logic rx_frm_err = 1'b0, rx_brk = 1'b0, rx_pop = 1'b0;
  logic tx_hold_empty = 1'b1, tx_shift_empty = 1'b1, status_rd = 1'b0;
  logic rls_irq_en = 1'b0, thre_irq_en = 1'b0;
  logic [7:0] lsr;
  logic rls_irq, thre_irq;

  line_status_unit #(.RX_DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .rx_push(rx_push),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rx_brk(rx_brk),
    .rx_pop(rx_pop), .tx_hold_empty(tx_hold_empty), .tx_shift_empty(tx_shift_empty),
    .status_rd(status_rd), .rls_irq_en(rls_irq_en), .thre_irq_en(thre_irq_en),
    .lsr(lsr), .rls_irq(rls_irq), .thre_irq(thre_irq)
  );

  int vectors = 0, misses = 0;
  bit model_on = 0;

  // behavioural model: queue of (id*8 + tag), tag bit0 parity, bit1 framing, bit2 break
  int mq[$];
  int next_id = 0;
  bit m_oe, m_pe, m_fe, m_bi, m_b7, m_dr, m_thre = 1, m_temt = 1, m_rls, m_tirq;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      {m_oe, m_pe, m_fe, m_bi, m_b7, m_dr, m_rls, m_tirq} = '0;
      m_thre = 1; m_temt = 1;
    end else begin
      int size0, before_id, cap, tag, htag;
      bit pop_ok, push_ok, ovr, chg, anyerr;
      size0     = mq.size();
      before_id = (size0 > 0) ? (mq[0] >> 3) : -1;
      cap       = fifo_mode ? DEPTH : 1;
      pop_ok    = rx_pop && (size0 > 0);
      push_ok   = rx_push && ((size0 - (pop_ok ? 1 : 0)) < cap);
      ovr       = rx_push && !push_ok;
      tag       = {29'd0, rx_brk, rx_frm_err, rx_par_err};
      if (pop_ok) void'(mq.pop_front());
      if (push_ok) begin mq.push_back(next_id * 8 + tag); next_id++; end
      chg  = (mq.size() > 0) && ((mq[0] >> 3) != before_id);
      htag = chg ? (mq[0] & 7) : 0;
      anyerr = 0;
      foreach (mq[i]) if ((mq[i] & 7) != 0) anyerr = 1;
      m_oe = ovr | (m_oe & !status_rd);
      m_pe = ((htag & 1) != 0) | (m_pe & !status_rd);
      m_fe = ((htag & 2) != 0) | (m_fe & !status_rd);
      m_bi = ((htag & 4) != 0) | (m_bi & !status_rd);
      m_b7 = fifo_mode && (anyerr || (m_b7 && !status_rd));
      m_dr = mq.size() > 0;
      m_thre = tx_hold_empty;
      m_temt = tx_hold_empty && tx_shift_empty;
      m_rls  = rls_irq_en && (m_oe | m_pe | m_fe | m_bi);
      m_tirq = thre_irq_en && m_thre;
    end
  end

  task automatic cmp(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      cmp("R2 ready",            int'(lsr[0]), int'(m_dr));
      cmp("R3 overrun",          int'(lsr[1]), int'(m_oe));
      cmp("R6 parity",           int'(lsr[2]), int'(m_pe));
      cmp("R6 framing",          int'(lsr[3]), int'(m_fe));
      cmp("R6 break",            int'(lsr[4]), int'(m_bi));
      cmp("R9 holding empty",    int'(lsr[5]), int'(m_thre));
      cmp("R9 transmitter empty",int'(lsr[6]), int'(m_temt));
      cmp("R8 fifo error",       int'(lsr[7]), int'(m_b7));
      cmp("R10 rls_irq",         int'(rls_irq), int'(m_rls));
      cmp("R11 thre_irq",        int'(thre_irq), int'(m_tirq));
    end
  end

  // apply one cycle of events, return at the following negedge
  task automatic drive(bit push, bit pop, bit [2:0] tg, bit rd);
    rx_push = push; rx_pop = pop; status_rd = rd;
    {rx_brk, rx_frm_err, rx_par_err} = tg;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1;
    cmp("R1 reset status", int'(lsr), 32'h60);
    cmp("R1 reset irqs", int'({rls_irq, thre_irq}), 0);

    // single holding location
    rls_irq_en = 1'b1;
    drive(1, 0, 3'b001, 0); cmp("R7 parity on arrival", int'(lsr), 32'h65);
    cmp("R10 irq with enable", int'(rls_irq), 1);
    drive(0, 0, 3'b000, 1); cmp("R4 read clears errors", int'(lsr), 32'h61);
    cmp("R10 irq drops", int'(rls_irq), 0);
    drive(1, 0, 3'b100, 0); cmp("R3 overrun when full", int'(lsr), 32'h63);
    drive(0, 1, 3'b000, 1); cmp("R3 dropped tag unseen", int'(lsr), 32'h60);
    drive(1, 0, 3'b010, 1); cmp("R5 event beats read", int'(lsr), 32'h69);
    drive(0, 1, 3'b000, 1); cmp("R2 empty again", int'(lsr), 32'h60);
    drive(0, 1, 3'b000, 0); cmp("R2 pop on empty ignored", int'(lsr), 32'h60);
    rls_irq_en = 1'b0;

    // receive FIFO
    fifo_mode = 1'b1;
    drive(1, 0, 3'b000, 0); cmp("R6 clean head", int'(lsr), 32'h61);
    drive(1, 0, 3'b001, 0); cmp("R6 tag hidden behind head", int'(lsr), 32'he1);
    drive(0, 0, 3'b000, 1); cmp("R8 read keeps fifo error", int'(lsr), 32'he1);
    drive(0, 1, 3'b000, 0); cmp("R6 tag at head", int'(lsr), 32'he5);
    drive(0, 0, 3'b000, 1); cmp("R4 read clears parity", int'(lsr), 32'he1);
    drive(0, 1, 3'b000, 0); cmp("R8 sticky until read", int'(lsr), 32'he0);
    drive(0, 0, 3'b000, 1); cmp("R8 cleared by read", int'(lsr), 32'h60);
    thre_irq_en = 1'b1; tx_hold_empty = 1'b1; tx_shift_empty = 1'b0;
    drive(0, 0, 3'b000, 1); cmp("R9 shift busy", int'(lsr), 32'h20);
    cmp("R11 thre irq", int'(thre_irq), 1);

    // random traffic, mode changed only while empty
    for (int blk = 0; blk < 6; blk++) begin
      fifo_mode = blk[0];
      for (int n = 0; n < 500; n++) begin
        bit [2:0] tg;
        tg[0] = ($urandom_range(0, 6) == 0);
        tg[1] = ($urandom_range(0, 6) == 0);
        tg[2] = ($urandom_range(0, 9) == 0);
        tx_hold_empty  = $urandom_range(0, 1);
        tx_shift_empty = $urandom_range(0, 1);
        if ($urandom_range(0, 15) == 0) rls_irq_en  = $urandom_range(0, 1);
        if ($urandom_range(0, 15) == 0) thre_irq_en = $urandom_range(0, 1);
        drive(($urandom_range(0, 9) < (blk[0] ? 6 : 4)),
              ($urandom_range(0, 9) < 3), tg,
              ($urandom_range(0, 4) == 0));
      end
      for (int d = 0; d < DEPTH + 2; d++) drive(0, 1, 3'b000, 0);
      drive(0, 0, 3'b000, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(8 * 150000);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule